// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit signal-processing core. A start strobe captures two signed 16-bit source operands, a destination operand and two mode selects. The unit forms the fractional product of the sources: their integer product doubled, so that bit 0 is always zero. It sign-extends that product to 36 bits and then adds it to or subtracts it from the destination.

The destination is either a 36-bit accumulator or a 16-bit register. A 36-bit accumulator is laid out as a 4-bit guard extension, a high word and a low word. A 16-bit register is widened before the arithmetic: it is sign-extended into the extension, placed in the high word, and followed by a zero low word. Its new value is the high word of the 36-bit result.

Five condition flags are registered together with the result: extension in use, unnormalized, negative, zero and overflow. The operation takes two pipeline stages. A one-cycle done pulse marks the cycle in which the result and the flags become valid.

Top module: `fmac36`

## Requirements
- R1: In accumulator mode (`dst16_i`=0, `sub_i`=0), `acc_o` becomes `dst_acc_i` + P modulo 2^36. P is the signed product of `src_a_i` and `src_b_i`, multiplied by two and sign-extended to 36 bits. Example: 0x4000 × 0x0AA0 added to 0x0_0003_0003 gives 0x0_0553_0003.
- R2: With `sub_i`=1, the result is the destination minus P modulo 2^36.
- R3: With `dst16_i`=1, the destination operand is `dst_reg_i` × 2^16 as a signed 36-bit value, and `reg_o` carries bits 31:16 of the result.
- R4: `done_o` is high exactly two clock cycles after the cycle in which `start_i` is sampled high. `acc_o`, `reg_o` and all flags keep their values in every cycle where `done_o` is low.
- R5: `flag_v_o` is 1 when the exact signed sum or difference lies outside the range of a signed 36-bit value.
- R6: `flag_e_o` is 0 when bits 35 down to 31 of the result are all equal, and 1 otherwise.
- R7: `flag_u_o` is 1 when bits 31 and 30 of the result are equal.
- R8: `flag_n_o` equals bit 35 of the result.
- R9: `flag_z_o` is 1 when all 36 result bits are zero.
- R10: While reset is held, and afterwards until the first result, `done_o`, `acc_o`, `reg_o` and all flags read 0.
- R11: The product of 0x8000 and 0x8000 is +1.0. It enters the sum as 0x0_8000_0000 and does not wrap to a negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture operands and begin an operation |
| sub_i | input | 1 | 1 subtracts the product, 0 adds it |
| dst16_i | input | 1 | 1 selects the 16-bit register destination |
| src_a_i | input | 16 | First signed source operand |
| src_b_i | input | 16 | Second signed source operand |
| dst_acc_i | input | 36 | 36-bit accumulator destination operand |
| dst_reg_i | input | 16 | 16-bit register destination operand |
| done_o | output | 1 | Result and flags valid this cycle |
| acc_o | output | 36 | 36-bit result |
| reg_o | output | 16 | High word of the result, the 16-bit write-back value |
| flag_e_o | output | 1 | Extension in use |
| flag_u_o | output | 1 | Unnormalized |
| flag_n_o | output | 1 | Negative |
| flag_z_o | output | 1 | Zero |
| flag_v_o | output | 1 | Overflow out of 36 bits |

## Verification
The bench drives the unit with operand pairs that reach full scale in both directions. If the guard bits were dropped, the overflow cases would either miss V or corrupt the extension. The case 0x8000 × 0x8000 exposes a product sign-extended from bit 31 instead of bit 32, because the expected +1.0 then turns into −1.0. The register-destination vectors catch a register that was zero-extended, or placed in the low word, because `reg_o` and the extension bits come out wrong. Separate probes cover the latency and hold behaviour: a done pulse that arrives one cycle early or late, and outputs that drift while idle.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef struct packed {
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
  } fmac_flags_t;
endpackage

// File: rtl/fmac_mul_stage.sv
module fmac_mul_stage #(
  parameter int OP_W  = 16,
  parameter int EXT_W = 4,
  localparam int ACC_W = EXT_W + 2*OP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sub,
  input  logic             dst16,
  input  logic [OP_W-1:0]  src_a,
  input  logic [OP_W-1:0]  src_b,
  input  logic [ACC_W-1:0] dst_acc,
  input  logic [OP_W-1:0]  dst_reg,
  output logic             valid_q,
  output logic             sub_q,
  output logic [ACC_W-1:0] prod_q,
  output logic [ACC_W-1:0] dest_q
);
  localparam int PROD_W = 2*OP_W;
  localparam int PAD_W  = ACC_W - PROD_W - 1;

  logic signed [PROD_W-1:0] prod_int;
  logic [ACC_W-1:0]         prod_d;
  logic [ACC_W-1:0]         dest_d;

  // doubling uses one extra bit so that full-scale times full-scale stays positive
  always_comb begin
    prod_int = $signed(src_a) * $signed(src_b);
    prod_d   = {{PAD_W{prod_int[PROD_W-1]}}, prod_int, 1'b0};
    dest_d   = dst16 ? {{EXT_W{dst_reg[OP_W-1]}}, dst_reg, {OP_W{1'b0}}} : dst_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= 1'b0;
      prod_q <= '0;
      dest_q <= '0;
    end else if (en) begin
      sub_q  <= sub;
      prod_q <= prod_d;
      dest_q <= dest_d;
    end
  end
endmodule

// File: rtl/fmac_addsub.sv
module fmac_addsub #(
  parameter int ACC_W = 36
) (
  input  logic             sub,
  input  logic [ACC_W-1:0] dest,
  input  logic [ACC_W-1:0] prod,
  output logic [ACC_W-1:0] sum,
  output logic             ovf
);
  logic [ACC_W:0] dest_x;
  logic [ACC_W:0] prod_x;
  logic [ACC_W:0] sum_x;

  always_comb begin
    dest_x = {dest[ACC_W-1], dest};
    prod_x = {prod[ACC_W-1], prod};
    sum_x  = sub ? (dest_x - prod_x) : (dest_x + prod_x);
    sum    = sum_x[ACC_W-1:0];
    ovf    = sum_x[ACC_W] ^ sum_x[ACC_W-1];
  end
endmodule

// File: rtl/fmac_flag_gen.sv
module fmac_flag_gen
  import fmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int EXT_W = 4,
  localparam int ACC_W = EXT_W + 2*OP_W,
  localparam int HI_B  = 2*OP_W - 1
) (
  input  logic [ACC_W-1:0] res,
  input  logic             ovf,
  output fmac_flags_t      flags
);
  logic [ACC_W-1:HI_B] guard;

  always_comb begin
    guard   = res[ACC_W-1:HI_B];
    flags.e = !((&guard) || !(|guard));
    flags.u = (res[HI_B] == res[HI_B-1]);
    flags.n = res[ACC_W-1];
    flags.z = (res == '0);
    flags.v = ovf;
  end
endmodule

// File: rtl/fmac36.sv
module fmac36
  import fmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int EXT_W = 4,
  localparam int ACC_W = EXT_W + 2*OP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic             dst16_i,
  input  logic [OP_W-1:0]  src_a_i,
  input  logic [OP_W-1:0]  src_b_i,
  input  logic [ACC_W-1:0] dst_acc_i,
  input  logic [OP_W-1:0]  dst_reg_i,
  output logic             done_o,
  output logic [ACC_W-1:0] acc_o,
  output logic [OP_W-1:0]  reg_o,
  output logic             flag_e_o,
  output logic             flag_u_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_v_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_sync;
  logic             s1_valid;
  logic             s1_sub;
  logic [ACC_W-1:0] s1_prod;
  logic [ACC_W-1:0] s1_dest;
  logic [ACC_W-1:0] sum_d;
  logic             ovf_d;
  fmac_flags_t      flags_d;
  fmac_flags_t      flags_q;
  logic [ACC_W-1:0] acc_q;
  logic             done_q;

  // reset asserts at once and is released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_sync_q[1];

  fmac_mul_stage #(.OP_W(OP_W), .EXT_W(EXT_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .en      (start_i),
    .sub     (sub_i),
    .dst16   (dst16_i),
    .src_a   (src_a_i),
    .src_b   (src_b_i),
    .dst_acc (dst_acc_i),
    .dst_reg (dst_reg_i),
    .valid_q (s1_valid),
    .sub_q   (s1_sub),
    .prod_q  (s1_prod),
    .dest_q  (s1_dest)
  );

  fmac_addsub #(.ACC_W(ACC_W)) u_add (
    .sub  (s1_sub),
    .dest (s1_dest),
    .prod (s1_prod),
    .sum  (sum_d),
    .ovf  (ovf_d)
  );

  fmac_flag_gen #(.OP_W(OP_W), .EXT_W(EXT_W)) u_flags (
    .res   (sum_d),
    .ovf   (ovf_d),
    .flags (flags_d)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      done_q <= 1'b0;
    end else begin
      done_q <= s1_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (s1_valid) begin
      acc_q   <= sum_d;
      flags_q <= flags_d;
    end
  end

  assign done_o   = done_q;
  assign acc_o    = acc_q;
  assign reg_o    = acc_q[2*OP_W-1:OP_W];
  assign flag_e_o = flags_q.e;
  assign flag_u_o = flags_q.u;
  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_v_o = flags_q.v;
endmodule

// File: rtl/fmac36_chk.sv
module fmac36_chk #(
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic [ACC_W-1:0] acc_o,
  input logic             flag_e_o,
  input logic             flag_u_o,
  input logic             flag_n_o,
  input logic             flag_z_o,
  input logic             flag_v_o
);
  localparam int HB = ACC_W - 5;

  assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ##2 done_o);

  assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i, 2));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(acc_o) && $stable({flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o})));

  assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_n_o == acc_o[ACC_W-1]));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_z_o == (acc_o == '0)));

  assert_ext_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_e_o == !((&acc_o[ACC_W-1:HB]) || !(|acc_o[ACC_W-1:HB]))));

  assert_unnorm_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_u_o == (acc_o[HB] == acc_o[HB-1])));
endmodule

bind fmac36 fmac36_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .start_i  (start_i),
  .done_o   (done_o),
  .acc_o    (acc_o),
  .flag_e_o (flag_e_o),
  .flag_u_o (flag_u_o),
  .flag_n_o (flag_n_o),
  .flag_z_o (flag_z_o),
  .flag_v_o (flag_v_o)
);

// File: tb/fmac36_tb.sv
module fmac36_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        sub_i = 1'b0;
  logic        dst16_i = 1'b0;
  logic [15:0] src_a_i = '0;
  logic [15:0] src_b_i = '0;
  logic [35:0] dst_acc_i = '0;
  logic [15:0] dst_reg_i = '0;
  logic        done_o;
  logic [35:0] acc_o;
  logic [15:0] reg_o;
  logic        flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fmac36 u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i), .dst16_i(dst16_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_acc_i(dst_acc_i), .dst_reg_i(dst_reg_i),
    .done_o(done_o), .acc_o(acc_o), .reg_o(reg_o), .flag_e_o(flag_e_o),
    .flag_u_o(flag_u_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o)
  );

  // entry: sub, dst16, a[16], b[16], dest_acc[36], dest_reg[16]
  localparam int NV = 9;
  localparam logic [85:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 16'h4000, 16'h0AA0, 36'h0_0003_0003, 16'h0000},
    {1'b1, 1'b0, 16'h4000, 16'h0AA0, 36'h0_0553_0003, 16'h0000},
    {1'b0, 1'b0, 16'h7FFF, 16'h7FFF, 36'h7_FFFF_FFFF, 16'h0000},
    {1'b1, 1'b0, 16'h7FFF, 16'h4000, 36'h8_0000_0000, 16'h0000},
    {1'b0, 1'b1, 16'h1234, 16'h2000, 36'h0_0000_0000, 16'h4000},
    {1'b1, 1'b1, 16'h8000, 16'h7FFF, 36'h0_0000_0000, 16'hC000},
    {1'b0, 1'b0, 16'h8000, 16'h4000, 36'h0_4000_0000, 16'h0000},
    {1'b0, 1'b0, 16'h0123, 16'hFF00, 36'hF_F000_0000, 16'h0000},
    {1'b1, 1'b0, 16'h0001, 16'h0001, 36'h0_0000_0000, 16'h0000}
  };

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // returns {e,u,n,z,v, result[35:0]}
  function automatic logic [40:0] model(input logic sub, input logic d16, input logic [15:0] a,
                                        input logic [15:0] b, input logic [35:0] dacc, input logic [15:0] dreg);
    longint p, d, s;
    logic [35:0] r;
    logic e, u, n, z, v;
    p = longint'($signed(a)) * longint'($signed(b)) * 2;
    d = d16 ? longint'($signed(dreg)) * 65536 : longint'($signed({{28{dacc[35]}}, dacc}));
    s = sub ? d - p : d + p;
    v = (s > 64'sh7_FFFF_FFFF) || (s < -64'sh8_0000_0000);
    r = s[35:0];
    e = !((r[35:31] == 5'b11111) || (r[35:31] == 5'b00000));
    u = (r[31] == r[30]);
    n = r[35];
    z = (r == 36'h0);
    return {e, u, n, z, v, r};
  endfunction

  task automatic issue(input logic sub, input logic d16, input logic [15:0] a, input logic [15:0] b,
                       input logic [35:0] dacc, input logic [15:0] dreg);
    sub_i = sub; dst16_i = d16; src_a_i = a; src_b_i = b; dst_acc_i = dacc; dst_reg_i = dreg;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R4", "done one cycle after start", 64'(done_o), 64'd0);
    @(negedge clk);
    check("R4", "done two cycles after start", 64'(done_o), 64'd1);
  endtask

  task automatic compare_all(input string req, input logic d16, input logic [40:0] exp);
    check(req, "acc", 64'(acc_o), 64'(exp[35:0]));
    if (d16) check("R3", "reg write-back", 64'(reg_o), 64'(exp[31:16]));
    check("R6", "E flag", 64'(flag_e_o), 64'(exp[40]));
    check("R7", "U flag", 64'(flag_u_o), 64'(exp[39]));
    check("R8", "N flag", 64'(flag_n_o), 64'(exp[38]));
    check("R9", "Z flag", 64'(flag_z_o), 64'(exp[37]));
    check("R5", "V flag", 64'(flag_v_o), 64'(exp[36]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [40:0] exp;
    logic [35:0] held;
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    check("R10", "done in reset", 64'(done_o), 64'd0);
    check("R10", "acc in reset", 64'(acc_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "acc after reset", 64'(acc_o), 64'd0);
    check("R10", "flags after reset", 64'({flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o}), 64'd0);
    check("R10", "reg after reset", 64'(reg_o), 64'd0);

    // R1: worked example with a fixed expected value
    issue(1'b0, 1'b0, 16'h4000, 16'h0AA0, 36'h0_0003_0003, 16'h0);
    check("R1", "example result", 64'(acc_o), 64'h0_0553_0003);

    // R11: full-scale negative squared is +1.0
    issue(1'b0, 1'b0, 16'h8000, 16'h8000, 36'h0, 16'h0);
    check("R11", "+1.0 product", 64'(acc_o), 64'h0_8000_0000);
    check("R11", "E set by +1.0", 64'(flag_e_o), 64'd1);
    check("R11", "no V on +1.0", 64'(flag_v_o), 64'd0);

    // table of vectors checked against the integer model
    for (int i = 0; i < NV; i++) begin
      logic [85:0] v;
      string req;
      v = VEC[i];
      issue(v[85], v[84], v[83:68], v[67:52], v[51:16], v[15:0]);
      exp = model(v[85], v[84], v[83:68], v[67:52], v[51:16], v[15:0]);
      req = v[84] ? "R3" : (v[85] ? "R2" : "R1");
      compare_all(req, v[84], exp);
    end

    // R4: outputs hold while idle although inputs move
    @(negedge clk);
    held = acc_o;
    src_a_i = 16'h7FFF; src_b_i = 16'h7FFF; dst_acc_i = 36'h1_2345_6789; sub_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R4", "idle hold acc", 64'(acc_o), 64'(held));
    check("R4", "no done while idle", 64'(done_o), 64'd0);

    // R4: done is a single pulse
    issue(1'b0, 1'b0, 16'h0100, 16'h0100, 36'h0, 16'h0);
    @(negedge clk);
    check("R4", "done pulse width", 64'(done_o), 64'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule